// File: doc/BRIEF.md
# Data-Processing ALU with Flag Update

This combinational block carries out the sixteen data-processing operations of a 32-bit integer core. It takes a first operand from the register file and a second operand that has already been through the barrel shifter, together with the shifter's carry-out. It returns the 32-bit result, a write enable for the destination register and the next N, Z, C and V flags.

Arithmetic operations share one carry-propagate adder. Operand swapping, inversion of the second adder input and the carry-in source are chosen from the opcode, so reverse subtraction and subtraction with borrow reuse the same path. Logical operations bypass the adder and take their carry from the shifter. The compare and test operations produce a value only for the flags. They never assert the write enable and always update the flags. Write-back, condition evaluation and status-register restore belong to the surrounding pipeline.

Top module: `dp_alu`

## Requirements
- R1: The opcode encoding is 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. AND, EOR, ORR, BIC (first AND NOT second), MOV (second) and MVN (NOT second) drive result_o with the bitwise value.
- R2: result_o is the 32-bit modular value of the arithmetic operations: SUB is first minus second, RSB is second minus first, ADD and ADC add, and ADC also adds flag C.
- R3: TST, TEQ, CMP and CMN (opcodes 8 to 11) never assert wr_en_o and always update the flags, whatever set_flags_i is.
- R4: For AND, EOR, ORR, BIC, MOV, MVN, TST and TEQ with flags updating, N is result bit 31 and Z is set when the result is zero. C equals shift_carry_i and V keeps its input value.
- R5: For ADD, ADC and CMN with flags updating, C is the unsigned carry out of bit 31 and V is the signed overflow of the addition.
- R6: For SUB, RSB and CMP with flags updating, C is 1 exactly when the minuend is at least the subtrahend as unsigned values. V is the signed overflow of the subtraction.
- R7: SBC computes first minus second minus NOT C, and RSC computes second minus first minus NOT C. Their C output is 1 only when no borrow results, counting that extra borrow.
- R8: When set_flags_i is 0 and the opcode is not a compare or test, flags_o equals flags_i.
- R9: All twelve operations other than the compare and test group assert wr_en_o.
- R10: Flags are packed as flags_i[3]=N, [2]=Z, [1]=C, [0]=V, and flags_o uses the same packing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 4 | Operation code (R1 encoding) |
| set_flags_i | input | 1 | Request to update the flags |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Shifted second operand |
| shift_carry_i | input | 1 | Carry-out of the shifter |
| flags_i | input | 4 | Current N, Z, C, V |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next N, Z, C, V |

## Verification
The hardest cases to reach are the carry and overflow boundaries of the borrow-in operations. SBC or RSC with equal operands and C clear must wrap to all ones and clear C, and the signed limits must overflow in one direction but not the other. The stimulus drives every opcode across every pair of 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF with both carry-in values. It compares the outputs with a reference that uses 33-bit comparisons instead of an adder, and adds directed cases that land exactly on these edges.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    LF_AND, LF_EOR, LF_ORR, LF_BIC, LF_MOV, LF_MVN
  } logic_fn_e;

  typedef enum logic [1:0] {
    CI_ZERO, CI_ONE, CI_FLAG
  } cin_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  typedef struct packed {
    logic      is_arith;
    logic      is_test;
    logic      swap;
    logic      inv_y;
    cin_sel_e  cin_sel;
    logic_fn_e lfn;
  } alu_ctrl_t;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] opcode_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.cin_sel  = CI_ZERO;
    ctrl_o.lfn      = LF_AND;
    unique case (alu_op_e'(opcode_i))
      OP_AND: ctrl_o.lfn = LF_AND;
      OP_EOR: ctrl_o.lfn = LF_EOR;
      OP_ORR: ctrl_o.lfn = LF_ORR;
      OP_BIC: ctrl_o.lfn = LF_BIC;
      OP_MOV: ctrl_o.lfn = LF_MOV;
      OP_MVN: ctrl_o.lfn = LF_MVN;
      OP_TST: begin ctrl_o.lfn = LF_AND; ctrl_o.is_test = 1'b1; end
      OP_TEQ: begin ctrl_o.lfn = LF_EOR; ctrl_o.is_test = 1'b1; end
      OP_ADD: begin ctrl_o.is_arith = 1'b1; end
      OP_CMN: begin ctrl_o.is_arith = 1'b1; ctrl_o.is_test = 1'b1; end
      OP_ADC: begin ctrl_o.is_arith = 1'b1; ctrl_o.cin_sel = CI_FLAG; end
      OP_SUB: begin
        ctrl_o.is_arith = 1'b1; ctrl_o.inv_y = 1'b1; ctrl_o.cin_sel = CI_ONE;
      end
      OP_CMP: begin
        ctrl_o.is_arith = 1'b1; ctrl_o.inv_y = 1'b1; ctrl_o.cin_sel = CI_ONE;
        ctrl_o.is_test  = 1'b1;
      end
      OP_RSB: begin
        ctrl_o.is_arith = 1'b1; ctrl_o.inv_y = 1'b1; ctrl_o.cin_sel = CI_ONE;
        ctrl_o.swap     = 1'b1;
      end
      OP_SBC: begin
        ctrl_o.is_arith = 1'b1; ctrl_o.inv_y = 1'b1; ctrl_o.cin_sel = CI_FLAG;
      end
      OP_RSC: begin
        ctrl_o.is_arith = 1'b1; ctrl_o.inv_y = 1'b1; ctrl_o.cin_sel = CI_FLAG;
        ctrl_o.swap     = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end

  // R3: compare/test group occupies opcodes 8..11
  always_comb begin
    assert_test_group_R3: assert (ctrl_o.is_test == (opcode_i[3:2] == 2'b10));
  end

endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] wide;

  always_comb begin
    wide   = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
    sum_o  = wide[MSB:0];
    cout_o = wide[WIDTH];
    // same-sign inputs giving an opposite-sign sum
    ovf_o  = (x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);
  end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic_fn_e        fn_i,
  output logic [WIDTH-1:0] out_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (fn_i)
        LF_AND:  out_o[i] = a_i[i] & b_i[i];
        LF_EOR:  out_o[i] = a_i[i] ^ b_i[i];
        LF_ORR:  out_o[i] = a_i[i] | b_i[i];
        LF_BIC:  out_o[i] = a_i[i] & ~b_i[i];
        LF_MOV:  out_o[i] = b_i[i];
        LF_MVN:  out_o[i] = ~b_i[i];
        default: out_o[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [3:0]       opcode_i,
  input  logic             set_flags_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             shift_carry_i,
  input  logic [3:0]       flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);

  localparam int unsigned MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  alu_flags_t       fl_in, fl_out;
  logic [WIDTH-1:0] add_x, add_y_raw, add_y, add_sum, logic_out;
  logic             add_cin, add_cout, add_ovf, upd;

  assign fl_in = alu_flags_t'(flags_i);

  dp_alu_decode u_decode (
    .opcode_i (opcode_i),
    .ctrl_o   (ctrl)
  );

  always_comb begin
    add_x     = ctrl.swap ? op_b_i : op_a_i;
    add_y_raw = ctrl.swap ? op_a_i : op_b_i;
    add_y     = ctrl.inv_y ? ~add_y_raw : add_y_raw;
    unique case (ctrl.cin_sel)
      CI_ONE:  add_cin = 1'b1;
      CI_FLAG: add_cin = fl_in.c;
      default: add_cin = 1'b0;
    endcase
  end

  dp_alu_adder #(.WIDTH(WIDTH)) u_adder (
    .x_i    (add_x),
    .y_i    (add_y),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .fn_i  (ctrl.lfn),
    .out_o (logic_out)
  );

  always_comb begin
    result_o = ctrl.is_arith ? add_sum : logic_out;
    wr_en_o  = ~ctrl.is_test;
    upd      = set_flags_i | ctrl.is_test;
    fl_out   = fl_in;
    if (upd) begin
      fl_out.n = result_o[MSB];
      fl_out.z = ~|result_o;
      fl_out.c = ctrl.is_arith ? add_cout : shift_carry_i;
      fl_out.v = ctrl.is_arith ? add_ovf : fl_in.v;
    end
    flags_o = fl_out;
  end

  // checks against port-level definitions
  always_comb begin
    if (opcode_i[3:2] == 2'b10)
      assert_test_no_write_R3: assert (!wr_en_o);
    else
      assert_write_enable_R9: assert (wr_en_o);
    if (!set_flags_i && opcode_i[3:2] != 2'b10)
      assert_flags_held_R8: assert (flags_o == flags_i);
    if (opcode_i inside {4'd0, 4'd1, 4'd8, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15})
      assert_logic_keeps_v_R4: assert (flags_o[0] == flags_i[0]);
    if ((set_flags_i || opcode_i[3:2] == 2'b10) && (opcode_i == 4'd2 || opcode_i == 4'd10))
      assert_sub_no_borrow_R6: assert (flags_o[1] == (op_a_i >= op_b_i));
    if (set_flags_i || opcode_i[3:2] == 2'b10)
      assert_zero_flag_R4: assert (flags_o[2] == (result_o == '0));
  end

endmodule

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic [3:0]  opcode;
  logic        set_flags;
  logic [31:0] op_a, op_b;
  logic        shift_carry;
  logic [3:0]  flags_in;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dp_alu dut_i (
    .opcode_i      (opcode),
    .set_flags_i   (set_flags),
    .op_a_i        (op_a),
    .op_b_i        (op_b),
    .shift_carry_i (shift_carry),
    .flags_i       (flags_in),
    .result_o      (result),
    .wr_en_o       (wr_en),
    .flags_o       (flags_out)
  );

  // reference: comparisons on 33-bit values, no adder inversion trick
  task automatic ref_model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic sc, input logic [3:0] fi, input logic sf,
                           output logic [31:0] r, output logic wr, output logic [3:0] fo);
    logic n, z, c, v, cin, upd;
    logic [32:0] s;
    cin = fi[1];
    c = sc; v = fi[0];
    case (op)
      4'd0, 4'd8: r = a & b;
      4'd1, 4'd9: r = a ^ b;
      4'd12:      r = a | b;
      4'd13:      r = b;
      4'd14:      r = a & ~b;
      4'd15:      r = ~b;
      4'd4, 4'd11, 4'd5: begin
        s = {1'b0, a} + {1'b0, b} + ((op == 4'd5) ? {32'd0, cin} : 33'd0);
        r = s[31:0]; c = s[32];
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'd2, 4'd10: begin
        r = a - b; c = (a >= b);
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'd3: begin
        r = b - a; c = (b >= a);
        v = (a[31] != b[31]) && (r[31] != b[31]);
      end
      4'd6: begin
        r = a - b - {31'd0, ~cin}; c = ({1'b0, a} >= ({1'b0, b} + {32'd0, ~cin}));
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      default: begin
        r = b - a - {31'd0, ~cin}; c = ({1'b0, b} >= ({1'b0, a} + {32'd0, ~cin}));
        v = (a[31] != b[31]) && (r[31] != b[31]);
      end
    endcase
    n = r[31]; z = (r == 32'd0);
    wr  = !(op >= 4'd8 && op <= 4'd11);
    upd = sf || !wr;
    fo  = upd ? {n, z, c, v} : fi;
  endtask

  task automatic check_vec(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic sc, input logic [3:0] fi, input logic sf,
                           input string req);
    logic [31:0] er;
    logic ew;
    logic [3:0] ef;
    bit bad;
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; shift_carry = sc; flags_in = fi; set_flags = sf;
    #(CLK_PERIOD / 4);
    ref_model(op, a, b, sc, fi, sf, er, ew, ef);
    checks++;
    bad = 1'b0;
    if (ew && result !== er) begin
      bad = 1'b1;
      $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h", req, op, a, b, result, er);
    end
    if (wr_en !== ew) begin
      bad = 1'b1;
      $display("FAIL %s op=%0d wr_en actual=%b expected=%b", req, op, wr_en, ew);
    end
    if (flags_out !== ef) begin
      bad = 1'b1;
      $display("FAIL %s op=%0d a=%h b=%h flags actual=%b expected=%b", req, op, a, b, flags_out, ef);
    end
    if (bad) errors++;
  endtask

  // hand-computed expectations, independent of the reference task
  task automatic check_fixed(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                             input logic [3:0] fi, input logic [31:0] er, input logic [3:0] ef,
                             input string req);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; shift_carry = 1'b0; flags_in = fi; set_flags = 1'b1;
    #(CLK_PERIOD / 4);
    checks++;
    if (result !== er || flags_out !== ef) begin
      errors++;
      $display("FAIL %s op=%0d result/flags actual=%h/%b expected=%h/%b",
               req, op, result, flags_out, er, ef);
    end
  endtask

  task automatic t_logic_ops;
    for (int op = 0; op < 16; op++)
      if (op inside {0, 1, 8, 9, 12, 13, 14, 15}) begin
        check_vec(4'(op), 32'hF0F0_1234, 32'h0FF0_00FF, 1'b1, 4'b0001, 1'b1, "R1 R4");
        check_vec(4'(op), 32'h0000_0000, 32'h0000_0000, 1'b0, 4'b1110, 1'b1, "R4");
      end
    check_fixed(4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'b0001, 32'hFFFF_0000, 4'b1001, "R1");
  endtask

  task automatic t_arith_ops;
    check_fixed(4'd4, 32'h7FFF_FFFF, 32'h1, 4'b0000, 32'h8000_0000, 4'b1001, "R5");
    check_fixed(4'd4, 32'hFFFF_FFFF, 32'h1, 4'b0000, 32'h0000_0000, 4'b0110, "R5");
    check_fixed(4'd2, 32'h0, 32'h1, 4'b0010, 32'hFFFF_FFFF, 4'b1000, "R6");
    check_fixed(4'd2, 32'h8000_0000, 32'h1, 4'b0000, 32'h7FFF_FFFF, 4'b0011, "R6");
    check_fixed(4'd3, 32'h5, 32'h9, 4'b0000, 32'h4, 4'b0010, "R2");
    check_vec(4'd5, 32'h1234_5678, 32'h1111_1111, 1'b0, 4'b0010, 1'b1, "R2");
  endtask

  task automatic t_borrow_ops;
    check_fixed(4'd6, 32'h10, 32'h10, 4'b0000, 32'hFFFF_FFFF, 4'b1000, "R7");
    check_fixed(4'd6, 32'h10, 32'h10, 4'b0010, 32'h0, 4'b0110, "R7");
    check_fixed(4'd7, 32'h3, 32'h3, 4'b0000, 32'hFFFF_FFFF, 4'b1000, "R7");
    check_fixed(4'd5, 32'hFFFF_FFFF, 32'h0, 4'b0010, 32'h0, 4'b0110, "R5");
  endtask

  task automatic t_test_ops;
    for (int op = 8; op < 12; op++) begin
      check_vec(4'(op), 32'h8000_0000, 32'h8000_0000, 1'b1, 4'b0000, 1'b0, "R3");
      check_vec(4'(op), 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 4'b1111, 1'b0, "R3");
    end
  endtask

  task automatic t_no_set_flags;
    for (int op = 0; op < 16; op++)
      if (!(op inside {8, 9, 10, 11})) begin
        check_vec(4'(op), 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 4'b0101, 1'b0, "R8 R9");
        check_vec(4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 4'b1010, 1'b0, "R8 R10");
      end
  endtask

  task automatic t_corner_sweep;
    logic [31:0] pts [4];
    pts[0] = 32'h0000_0000; pts[1] = 32'h7FFF_FFFF;
    pts[2] = 32'h8000_0000; pts[3] = 32'hFFFF_FFFF;
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int c = 0; c < 2; c++)
            check_vec(4'(op), pts[i], pts[j], 1'(i ^ j ^ c),
                      {1'(i & 1), 1'(j & 1), 1'(c), 1'(~c)}, 1'b1, "R2 R5 R6 R7 R10");
  endtask

  initial begin
    opcode = '0; op_a = '0; op_b = '0; shift_carry = 1'b0; flags_in = '0; set_flags = 1'b0;
    t_logic_ops();
    t_arith_ops();
    t_borrow_ops();
    t_test_ops();
    t_no_set_flags();
    t_corner_sweep();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule